// File: doc/BRIEF.md
# APB Rule Monitor

A passive observer placed beside one APB requester or completer. Each clock it samples the select lines, enable, address, direction, write data, ready and the completer error line, compares them against the previous cycle, and records any breach of the phase-ordering and signal-stability rules in a sticky flag, one flag per rule. It drives nothing on the bus. It also counts completed transfers and completed transfers that carried an error response.

A cycle is a *completion* when some select bit, enable and ready are all high. A *setup* cycle has some select bit high and enable low. A *stalled access* has some select bit high, enable high and ready low. Each flag is raised by the clock edge that ends the offending cycle. Flags and counters stay put until `flag_clr` is pulsed or reset is asserted. The asynchronous active-low reset is released to the logic two clock edges after `rst_n` rises. Bus cycles inside that window are not observed, and the window counts as an idle bus.

Top module: `apb_rule_monitor`

## Requirements
- R1: After reset, `rule_flags`, `err_advisory`, `xfer_count` and `err_count` are all zero.
- R2: `rule_flags[0]` is set when enable is high and it was low in the previous cycle, and that previous cycle was not a setup cycle (no select bit was high).
- R3: `rule_flags[1]` is set when a setup cycle is followed by a cycle with enable low.
- R4: `rule_flags[3]` is set when a setup cycle is followed by a cycle whose select, address, direction or write data differ from the setup cycle.
- R5: `rule_flags[2]` is set when a stalled access is followed by a cycle whose select, enable, address, direction or write data differ from the stalled cycle.
- R6: `rule_flags[4]` is set when a completion is followed by a cycle with enable high.
- R7: `rule_flags[5]` is set in any cycle where enable is high and every select bit is low.
- R8: `rule_flags[6]` is set in any cycle where more than one select bit is high.
- R9: `err_advisory` is set when the error line is high in a cycle that is not a completion. An error line that is high during a completion does not set it.
- R10: `xfer_count` counts completions. `err_count` counts completions with the error line high.
- R11: Both counters are CNT_W bits wide and hold at their all-ones value instead of wrapping.
- R12: Flags stay set through any later traffic. A `flag_clr` pulse zeroes every flag and both counters at the next edge, and it takes priority over any event seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_clr | input | 1 | Synchronous clear of flags and counters |
| bus_sel | input | NSEL | Completer select lines |
| bus_en | input | 1 | Enable (access phase) |
| bus_addr | input | AW | Address |
| bus_wr | input | 1 | Direction, high for write |
| bus_wdata | input | DW | Write data |
| bus_rdy | input | 1 | Completer ready |
| bus_err | input | 1 | Completer error response |
| rule_flags | output | 7 | Sticky rule violation flags |
| err_advisory | output | 1 | Sticky flag for error line high outside a completion |
| xfer_count | output | CNT_W | Saturating completion count |
| err_count | output | CNT_W | Saturating errored-completion count |

## Verification
The bench builds the monitor with three select lines, 8-bit address and data, and CNT_W set to 4. The three select lines make a two-hot select reachable. The 4-bit counters reach their ceiling of 15 after a few dozen cycles, so seventeen errored transfers show both counters holding instead of wrapping. The wide 16-bit default keeps the same saturation logic, which only this narrow build can exercise within a short run.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
  localparam int NUM_RULES       = 7;
  localparam int RB_EN_NO_SETUP  = 0;
  localparam int RB_SETUP_LONG   = 1;
  localparam int RB_WAIT_CHANGE  = 2;
  localparam int RB_SETUP_CHANGE = 3;
  localparam int RB_EN_AFTER_END = 4;
  localparam int RB_EN_NO_SEL    = 5;
  localparam int RB_SEL_MULTI    = 6;
endpackage

// File: rtl/apb_mon_history.sv
module apb_mon_history #(
  parameter int NSEL = 4,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEL-1:0] sel,
  input  logic            en,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic            rdy,
  output logic [NSEL-1:0] p_sel,
  output logic            p_en,
  output logic [AW-1:0]   p_addr,
  output logic            p_wr,
  output logic [DW-1:0]   p_wdata,
  output logic            p_rdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sel   <= '0;
      p_en    <= 1'b0;
      p_addr  <= '0;
      p_wr    <= 1'b0;
      p_wdata <= '0;
      p_rdy   <= 1'b0;
    end else begin
      p_sel   <= sel;
      p_en    <= en;
      p_addr  <= addr;
      p_wr    <= wr;
      p_wdata <= wdata;
      p_rdy   <= rdy;
    end
  end
endmodule

// File: rtl/apb_mon_rules.sv
module apb_mon_rules
  import apb_mon_pkg::*;
#(
  parameter int NSEL = 4,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic [NSEL-1:0]      sel,
  input  logic                 en,
  input  logic [AW-1:0]        addr,
  input  logic                 wr,
  input  logic [DW-1:0]        wdata,
  input  logic                 rdy,
  input  logic                 err,
  input  logic [NSEL-1:0]      p_sel,
  input  logic                 p_en,
  input  logic [AW-1:0]        p_addr,
  input  logic                 p_wr,
  input  logic [DW-1:0]        p_wdata,
  input  logic                 p_rdy,
  output logic [NUM_RULES-1:0] hit,
  output logic                 adv_hit,
  output logic                 done,
  output logic                 done_err
);
  logic p_setup, p_stall, p_done, moved;

  always_comb begin
    p_setup  = (|p_sel) && !p_en;
    p_stall  = (|p_sel) && p_en && !p_rdy;
    p_done   = (|p_sel) && p_en && p_rdy;
    moved    = (sel != p_sel) || (addr != p_addr) || (wr != p_wr) || (wdata != p_wdata);
    done     = (|sel) && en && rdy;
    done_err = done && err;
    adv_hit  = err && !done;

    hit                  = '0;
    hit[RB_EN_NO_SETUP]  = en && !p_en && !(|p_sel);
    hit[RB_SETUP_LONG]   = p_setup && !en;
    hit[RB_WAIT_CHANGE]  = p_stall && (moved || !en);
    hit[RB_SETUP_CHANGE] = p_setup && moved;
    hit[RB_EN_AFTER_END] = p_done && en;
    hit[RB_EN_NO_SEL]    = en && !(|sel);
    hit[RB_SEL_MULTI]    = $countones(sel) > 1;
  end
endmodule

// File: rtl/apb_mon_sticky.sv
module apb_mon_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_d, bit_q;
    always_comb bit_d = clr ? 1'b0 : (bit_q | set[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/apb_mon_satcnt.sv
module apb_mon_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (q != TOP));
    cnt_d  = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cnt_en) q <= cnt_d;
  end
endmodule

// File: rtl/apb_rule_monitor.sv
module apb_rule_monitor
  import apb_mon_pkg::*;
#(
  parameter int NSEL  = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flag_clr,
  input  logic [NSEL-1:0]      bus_sel,
  input  logic                 bus_en,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_rdy,
  input  logic                 bus_err,
  output logic [NUM_RULES-1:0] rule_flags,
  output logic                 err_advisory,
  output logic [CNT_W-1:0]     xfer_count,
  output logic [CNT_W-1:0]     err_count
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [NSEL-1:0]      p_sel;
  logic                 p_en, p_wr, p_rdy;
  logic [AW-1:0]        p_addr;
  logic [DW-1:0]        p_wdata;
  logic [NUM_RULES-1:0] hit;
  logic                 adv_hit, done, done_err;

  apb_mon_history #(.NSEL(NSEL), .AW(AW), .DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_core_n),
    .sel(bus_sel), .en(bus_en), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rdy(bus_rdy),
    .p_sel(p_sel), .p_en(p_en), .p_addr(p_addr), .p_wr(p_wr),
    .p_wdata(p_wdata), .p_rdy(p_rdy)
  );

  apb_mon_rules #(.NSEL(NSEL), .AW(AW), .DW(DW)) u_rules (
    .sel(bus_sel), .en(bus_en), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rdy(bus_rdy), .err(bus_err),
    .p_sel(p_sel), .p_en(p_en), .p_addr(p_addr), .p_wr(p_wr),
    .p_wdata(p_wdata), .p_rdy(p_rdy),
    .hit(hit), .adv_hit(adv_hit), .done(done), .done_err(done_err)
  );

  apb_mon_sticky #(.W(NUM_RULES)) u_flags (
    .clk(clk), .rst_n(rst_core_n), .clr(flag_clr), .set(hit), .q(rule_flags)
  );

  apb_mon_sticky #(.W(1)) u_adv (
    .clk(clk), .rst_n(rst_core_n), .clr(flag_clr), .set(adv_hit), .q(err_advisory)
  );

  apb_mon_satcnt #(.W(CNT_W)) u_xfer_cnt (
    .clk(clk), .rst_n(rst_core_n), .clr(flag_clr), .inc(done), .q(xfer_count)
  );

  apb_mon_satcnt #(.W(CNT_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_core_n), .clr(flag_clr), .inc(done_err), .q(err_count)
  );
endmodule

// File: rtl/apb_rule_monitor_chk.sv
module apb_rule_monitor_chk #(
  parameter int NSEL  = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_int,
  input logic             flag_clr,
  input logic [NSEL-1:0]  bus_sel,
  input logic             bus_en,
  input logic             bus_rdy,
  input logic             bus_err,
  input logic [6:0]       rule_flags,
  input logic             err_advisory,
  input logic [CNT_W-1:0] xfer_count,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CEIL = '1;

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_int)
    !flag_clr |=> ((rule_flags & $past(rule_flags)) == $past(rule_flags)));

  // R12
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_int)
    flag_clr |=> (rule_flags == '0 && !err_advisory && xfer_count == '0 && err_count == '0));

  // R7
  en_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_en && bus_sel == '0 && !flag_clr) |=> rule_flags[5]);

  // R8
  sel_multi_chk: assert property (@(posedge clk) disable iff (!rst_int)
    ($countones(bus_sel) > 1 && !flag_clr) |=> rule_flags[6]);

  // R3
  setup_long_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_sel != '0 && !bus_en && !flag_clr) ##1 (!bus_en && !flag_clr) |=> rule_flags[1]);

  // R9
  adv_err_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_err && !(bus_sel != '0 && bus_en && bus_rdy) && !flag_clr) |=> err_advisory);

  // R10
  err_le_xfer_chk: assert property (@(posedge clk) disable iff (!rst_int)
    err_count <= xfer_count);

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (xfer_count == CEIL && !flag_clr) |=> xfer_count == CEIL);
endmodule

bind apb_rule_monitor apb_rule_monitor_chk #(.NSEL(NSEL), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_int(rst_core_n), .flag_clr(flag_clr),
  .bus_sel(bus_sel), .bus_en(bus_en), .bus_rdy(bus_rdy), .bus_err(bus_err),
  .rule_flags(rule_flags), .err_advisory(err_advisory),
  .xfer_count(xfer_count), .err_count(err_count)
);

// File: tb/apb_rule_monitor_bench.sv
module apb_rule_monitor_bench;
  localparam int NSEL = 3;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int CW   = 4;
  localparam int NR   = 7;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, flag_clr;
  logic [NSEL-1:0] bus_sel;
  logic            bus_en, bus_wr, bus_rdy, bus_err;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic [NR-1:0]   rule_flags;
  logic            err_advisory;
  logic [CW-1:0]   xfer_count, err_count;

  apb_rule_monitor #(.NSEL(NSEL), .AW(AW), .DW(DW), .CNT_W(CW)) u_apb_rule_monitor (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_err(bus_err),
    .rule_flags(rule_flags), .err_advisory(err_advisory),
    .xfer_count(xfer_count), .err_count(err_count)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  typedef struct packed {
    logic [NSEL-1:0] sel;
    logic            en;
    logic [AW-1:0]   addr;
    logic            wr;
    logic [DW-1:0]   wdata;
    logic            rdy;
    logic            err;
  } smp_t;

  smp_t          hist[$];
  int            since_rel;
  logic [NR-1:0] exp_flags;
  logic          exp_adv;
  int            exp_xfer, exp_err;

  function automatic string req_of(int b);
    case (b)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference: flags, advisory and counts from the requirements.
  always @(posedge clk or negedge rst_n) begin
    smp_t c, p;
    int   ones;
    bit   done, p_any;
    logic [NR-1:0] v;
    if (!rst_n) begin
      since_rel = 0;
      exp_flags = '0;
      exp_adv   = 1'b0;
      exp_xfer  = 0;
      exp_err   = 0;
      hist.delete();
      hist.push_back('0);
    end else if (since_rel < 2) begin
      since_rel++;
    end else begin
      c = '{bus_sel, bus_en, bus_addr, bus_wr, bus_wdata, bus_rdy, bus_err};
      p = hist[0];
      ones = 0;
      for (int i = 0; i < NSEL; i++) if (c.sel[i]) ones++;
      p_any = (p.sel != '0);
      done  = (c.sel != '0) && c.en && c.rdy;
      v = '0;
      if (c.en && !p.en && !p_any) v[0] = 1'b1;
      if (p_any && !p.en && !c.en) v[1] = 1'b1;
      if (p_any && p.en && !p.rdy &&
          (c.sel != p.sel || !c.en || c.addr != p.addr || c.wr != p.wr || c.wdata != p.wdata))
        v[2] = 1'b1;
      if (p_any && !p.en &&
          (c.sel != p.sel || c.addr != p.addr || c.wr != p.wr || c.wdata != p.wdata))
        v[3] = 1'b1;
      if (p_any && p.en && p.rdy && c.en) v[4] = 1'b1;
      if (c.en && c.sel == '0) v[5] = 1'b1;
      if (ones > 1) v[6] = 1'b1;
      if (flag_clr) begin
        exp_flags = '0;
        exp_adv   = 1'b0;
        exp_xfer  = 0;
        exp_err   = 0;
      end else begin
        exp_flags = exp_flags | v;
        if (c.err && !done) exp_adv = 1'b1;
        if (done) begin
          if (exp_xfer < CMAX) exp_xfer++;
          if (c.err && exp_err < CMAX) exp_err++;
        end
      end
      hist[0] = c;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!ended) begin
      for (int b = 0; b < NR; b++) begin
        checks++;
        if (rule_flags[b] !== exp_flags[b]) begin
          fails++;
          $display("FAIL %s flag bit %0d actual %0b expected %0b", req_of(b), b, rule_flags[b], exp_flags[b]);
        end
      end
      checks++;
      if (err_advisory !== exp_adv) begin
        fails++;
        $display("FAIL R9 advisory actual %0b expected %0b", err_advisory, exp_adv);
      end
      checks++;
      if (int'(xfer_count) != exp_xfer) begin
        fails++;
        $display("FAIL R10 xfer_count actual %0d expected %0d", xfer_count, exp_xfer);
      end
      checks++;
      if (int'(err_count) != exp_err) begin
        fails++;
        $display("FAIL R10 err_count actual %0d expected %0d", err_count, exp_err);
      end
    end
  end

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [NSEL-1:0] s, input logic e, input logic [AW-1:0] a,
                      input logic w, input logic [DW-1:0] d, input logic r,
                      input logic er, input logic c = 1'b0);
    @(negedge clk);
    bus_sel = s; bus_en = e; bus_addr = a; bus_wr = w;
    bus_wdata = d; bus_rdy = r; bus_err = er; flag_clr = c;
  endtask

  task automatic idle();
    step('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic clear();
    step('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1);
    idle();
  endtask

  task automatic xfer(input logic [NSEL-1:0] s, input logic [AW-1:0] a, input logic w,
                      input logic [DW-1:0] d, input int waits, input logic er);
    step(s, 1'b0, a, w, d, 1'b0, 1'b0);
    for (int k = 0; k < waits; k++) step(s, 1'b1, a, w, d, 1'b0, 1'b0);
    step(s, 1'b1, a, w, d, 1'b1, er);
  endtask

  initial begin
    #2000000;
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flag_clr = 1'b0; bus_sel = '0; bus_en = 1'b0; bus_addr = '0;
    bus_wr = 1'b0; bus_wdata = '0; bus_rdy = 1'b0; bus_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    // R1 reset state
    expect_eq("R1 flags", int'(rule_flags), 0);
    expect_eq("R1 counts", int'(xfer_count) + int'(err_count) + int'(err_advisory), 0);

    // R10 clean write, then errored read with two waits
    xfer(3'b001, 8'h10, 1'b1, 8'hA5, 0, 1'b0); idle();
    expect_eq("R10 one transfer", int'(xfer_count), 1);
    xfer(3'b010, 8'h20, 1'b0, 8'h00, 2, 1'b1); idle();
    expect_eq("R10 errored read", int'(err_count), 1);
    expect_eq("R9 error in completion ignored", int'(err_advisory), 0);

    // R6 back-to-back transfers on same select are legal
    xfer(3'b100, 8'h30, 1'b0, 8'h00, 0, 1'b0);
    xfer(3'b100, 8'h34, 1'b1, 8'h5A, 1, 1'b0); idle();
    expect_eq("R6 back-to-back clean", int'(rule_flags), 0);
    expect_eq("R10 four transfers", int'(xfer_count), 4);

    // R2 enable without setup, then sticky R12
    step(3'b001, 1'b1, 8'h40, 1'b1, 8'h11, 1'b1, 1'b0); idle();
    expect_eq("R2 enable without setup", int'(rule_flags[0]), 1);
    repeat (3) idle();
    expect_eq("R12 flag sticky", int'(rule_flags[0]), 1);
    clear();
    expect_eq("R12 clear flags", int'(rule_flags), 0);
    expect_eq("R12 clear counts", int'(xfer_count), 0);

    // R3 setup lasting two cycles
    step(3'b010, 1'b0, 8'h50, 1'b0, 8'h00, 1'b0, 1'b0);
    step(3'b010, 1'b0, 8'h50, 1'b0, 8'h00, 1'b0, 1'b0); idle();
    expect_eq("R3 setup too long", int'(rule_flags[1]), 1);
    clear();

    // R4 address change from setup to access
    step(3'b001, 1'b0, 8'h60, 1'b1, 8'h22, 1'b0, 1'b0);
    step(3'b001, 1'b1, 8'h61, 1'b1, 8'h22, 1'b1, 1'b0); idle();
    expect_eq("R4 setup change", int'(rule_flags[3]), 1);
    expect_eq("R5 not raised by setup change", int'(rule_flags[2]), 0);
    clear();

    // R5 write data change during wait
    step(3'b100, 1'b0, 8'h70, 1'b1, 8'h33, 1'b0, 1'b0);
    step(3'b100, 1'b1, 8'h70, 1'b1, 8'h33, 1'b0, 1'b0);
    step(3'b100, 1'b1, 8'h70, 1'b1, 8'h34, 1'b0, 1'b0);
    step(3'b100, 1'b1, 8'h70, 1'b1, 8'h34, 1'b1, 1'b0); idle();
    expect_eq("R5 wait change", int'(rule_flags[2]), 1);
    expect_eq("R4 not raised by wait change", int'(rule_flags[3]), 0);
    clear();

    // R6 enable held after completion
    step(3'b010, 1'b0, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0);
    step(3'b010, 1'b1, 8'h80, 1'b0, 8'h00, 1'b1, 1'b0);
    step(3'b010, 1'b1, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0); idle();
    expect_eq("R6 enable after completion", int'(rule_flags[4]), 1);
    clear();

    // R7 enable with no select
    step(3'b000, 1'b1, 8'h90, 1'b0, 8'h00, 1'b0, 1'b0); idle();
    expect_eq("R7 enable no select", int'(rule_flags[5]), 1);
    clear();

    // R8 two selects high
    step(3'b011, 1'b0, 8'hA0, 1'b0, 8'h00, 1'b0, 1'b0); idle();
    expect_eq("R8 multi select", int'(rule_flags[6]), 1);
    clear();

    // R9 error line high while idle
    step('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1); idle();
    expect_eq("R9 stray error", int'(err_advisory), 1);
    clear();
    expect_eq("R12 clear advisory", int'(err_advisory), 0);

    // R12 clear wins over a violation in the same cycle
    step(3'b000, 1'b1, 8'hB0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1); idle();
    expect_eq("R12 clear priority", int'(rule_flags), 0);

    // R11 saturation
    for (int n = 0; n < 17; n++) xfer(3'b001, 8'hC0, 1'b1, 8'h44, 0, 1'b1);
    idle();
    expect_eq("R11 xfer saturates", int'(xfer_count), CMAX);
    expect_eq("R11 err saturates", int'(err_count), CMAX);
    expect_eq("R11 no flags on clean stream", int'(rule_flags), 0);

    idle(); idle();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule